// File: doc/BRIEF.md
# Six-Channel Motor-Control PWM Generator

This block drives six pulse-width modulated lines for motor and power-stage control. A single 16-bit counter sets the period for all six lines, and each line compares that counter against its own 16-bit duty value. The counter advances on a tick. The tick comes from the system clock or from an external tick input, and a power-of-two prescaler then divides it. The counter can run as a sawtooth (edge-aligned) or as a triangle (center-aligned).

The six lines form three pairs: lines 0/1, 2/3 and 4/5. Each pair can run its two lines independently, make the odd line follow the even line, or make the odd line the inverse of the even line. In the inverse mode, a programmable dead time holds back every rising edge so that the two switches of a half-bridge never conduct together. A group switch makes pairs 1 and 2 reuse the duty values of pair 0. This suits three-phase drives, where the phases share one duty setting.

Software writes period and duty values into shadow registers. A load command moves them into the working set at the next period boundary, so a change never tears a period. A one-clock event pulse marks each boundary.

Top module: `pwm6_motor_pwm`

## Requirements
- R1: After reset, and on any clock whose previous clock had the run bit (control bit 0) clear, all six outputs and the event pulse are low.
- R2: With control bit 1 clear (edge-aligned), the counter steps through 0..P and wraps, so a period is P+1 ticks. A line is high while the counter is below its duty D, which gives min(D, P+1) high ticks per period: a duty of 0 stays low and a duty above P stays high.
- R3: With control bit 1 set (center-aligned), the counter rises 0..P and falls back to 0, so a period is 2P ticks. A line is high for 2D-1 ticks when 1<=D<=P, is always high when D>P, and is always low when D=0.
- R4: Control bit 2 picks the tick source: 0 selects every system clock, 1 selects the external tick input. Control bits 5:3 hold an exponent e, and the counter advances once every 2^e source ticks.
- R5: Writes to the period (address 1) and duty registers (addresses 2..7 for lines 0..5) have no effect until a write to address 9 arms a load. The values then move at the next period boundary, or on the next clock while the run bit is clear.
- R6: The event output pulses for exactly one clock each time the counter returns to zero at a period boundary, once per period.
- R7: With control bit 6 set (group mode), lines 2 and 4 use the working duty of line 0 and lines 3 and 5 use that of line 1, and the duty registers of lines 2..5 are ignored.
- R8: A pair whose 2-bit mode field (control bits 8:7, 10:9, 12:11 for pairs 0, 1, 2) is 2 (synchronous) drives its odd line equal to its even line.
- R9: A pair whose mode field is 1 (complementary) drives its odd line as the inverse of the even line's compare. Each rising edge of both lines is delayed by the dead-time count (address 8, bits 7:0) in counter ticks, a high phase shorter than that count never appears, and the two lines are never high together.
- R10: A pair whose mode field is 0 (independent) drives each of its lines from that line's own duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | External tick, counted when the external source is selected |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0 control, 1 period, 2..7 duty, 8 dead time, 9 load) |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 6 | Registered PWM lines, bit n is line n |
| period_evt | output | 1 | One-clock pulse at each period boundary |

## Verification
On every clock, the assertions check the following. Complementary pairs are never high together. Synchronous pairs stay equal. The event pulse coincides with a zero counter. The working period changes only at a boundary or while stopped. Outputs are quiet after a stopped clock. Duty ratios under both counter shapes, the prescaler and external tick rates, shadow holding before a load, group aliasing, and the exact dead-time shortening and short-pulse suppression can only be shown by the bench. It does this by counting high clocks over whole periods for each scenario.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;

  typedef enum logic [1:0] {
    PM_INDEP = 2'd0,
    PM_COMP  = 2'd1,
    PM_SYNC  = 2'd2,
    PM_SPARE = 2'd3
  } pair_mode_e;

  localparam int unsigned PRE_W = 3;

  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_PERIOD = 1;
  localparam int unsigned A_DUTY0  = 2;
  localparam int unsigned A_DEAD   = 8;
  localparam int unsigned A_LOAD   = 9;

  localparam int unsigned CB_RUN     = 0;
  localparam int unsigned CB_CENTER  = 1;
  localparam int unsigned CB_EXT     = 2;
  localparam int unsigned CB_PRE_LO  = 3;
  localparam int unsigned CB_GROUP   = 6;
  localparam int unsigned CB_MODE_LO = 7;

  typedef struct packed {
    logic             run;
    logic             center;
    logic             ext_sel;
    logic [PRE_W-1:0] pre_exp;
    logic             group;
  } ctrl_t;

endpackage

// File: rtl/pwm6_regs.sv
module pwm6_regs
  import pwm6_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NPAIR = 3,
  parameter int DTW   = 8,
  parameter int AW    = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [DW-1:0]                 wr_data,
  input  logic                          bound,
  output ctrl_t                         ctrl_q,
  output pair_mode_e [NPAIR-1:0]        mode_q,
  output logic [DW-1:0]                 per_act,
  output logic [2*NPAIR-1:0][DW-1:0]    duty_act,
  output logic [DTW-1:0]                dead_q
);
  localparam int NCH = 2 * NPAIR;

  logic [DW-1:0]          per_sh;
  logic [NCH-1:0][DW-1:0] duty_sh;
  logic                   load_pend;
  logic                   xfer;
  logic                   wr_ctrl, wr_per, wr_dead, wr_load;

  assign wr_ctrl = wr_en && (wr_addr == AW'(A_CTRL));
  assign wr_per  = wr_en && (wr_addr == AW'(A_PERIOD));
  assign wr_dead = wr_en && (wr_addr == AW'(A_DEAD));
  assign wr_load = wr_en && (wr_addr == AW'(A_LOAD));

  // working set follows the shadows only at a boundary or while halted
  assign xfer = load_pend && (bound || !ctrl_q.run);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      mode_q    <= {NPAIR{PM_INDEP}};
      per_sh    <= '0;
      duty_sh   <= '0;
      per_act   <= '0;
      duty_act  <= '0;
      dead_q    <= '0;
      load_pend <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run     <= wr_data[CB_RUN];
        ctrl_q.center  <= wr_data[CB_CENTER];
        ctrl_q.ext_sel <= wr_data[CB_EXT];
        ctrl_q.pre_exp <= wr_data[CB_PRE_LO +: PRE_W];
        ctrl_q.group   <= wr_data[CB_GROUP];
        for (int p = 0; p < NPAIR; p++) begin
          mode_q[p] <= pair_mode_e'(wr_data[CB_MODE_LO + 2*p +: 2]);
        end
      end
      if (wr_per)  per_sh <= wr_data;
      if (wr_dead) dead_q <= wr_data[DTW-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (wr_en && (wr_addr == AW'(A_DUTY0 + i))) duty_sh[i] <= wr_data;
      end
      if (xfer) begin
        per_act  <= per_sh;
        duty_act <= duty_sh;
      end
      load_pend <= (load_pend && !xfer) || wr_load;
    end
  end

endmodule

// File: rtl/pwm6_tick.sv
module pwm6_tick
  import pwm6_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ext_sel,
  input  logic             ext_tick,
  input  logic [PRE_W-1:0] pre_exp,
  output logic             ce
);
  localparam int CW = (1 << PRE_W) - 1;

  logic          src;
  logic [CW-1:0] pcnt;
  logic [CW-1:0] mask;

  assign src  = ext_sel ? ext_tick : 1'b1;
  assign mask = ~({CW{1'b1}} << pre_exp);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      ce   <= 1'b0;
    end else begin
      ce <= src && ((pcnt & mask) == mask);
      if (src) pcnt <= pcnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm6_counter.sv
module pwm6_counter #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          center,
  input  logic          ce,
  input  logic [DW-1:0] period,
  output logic [DW-1:0] cnt_q,
  output logic          bound
);
  logic          up_q;
  logic [DW-1:0] cnt_d;
  logic          up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    bound = 1'b0;
    if (!run) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (ce) begin
      if (!center) begin
        up_d = 1'b1;
        if (cnt_q >= period) begin
          cnt_d = '0;
          bound = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (up_q) begin
        if (cnt_q >= period) begin
          if (period == '0) begin
            cnt_d = '0;
            bound = 1'b1;
          end else begin
            up_d  = 1'b0;
            cnt_d = cnt_q - 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q <= DW'(1)) begin
          cnt_d = '0;
          up_d  = 1'b1;
          bound = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

endmodule

// File: rtl/pwm6_pair.sv
module pwm6_pair
  import pwm6_pkg::*;
#(
  parameter int DW  = 16,
  parameter int DTW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           ce,
  input  pair_mode_e     mode,
  input  logic [DW-1:0]  cnt,
  input  logic [DW-1:0]  duty_a,
  input  logic [DW-1:0]  duty_b,
  input  logic [DTW-1:0] dead,
  output logic [1:0]     pwm
);
  logic           raw_a, raw_b;
  logic [1:0]     req;
  logic [1:0]     q;
  logic [DTW-1:0] dt_eff;

  assign raw_a  = cnt < duty_a;
  assign raw_b  = cnt < duty_b;
  assign dt_eff = (mode == PM_COMP) ? dead : '0;

  always_comb begin
    unique case (mode)
      PM_COMP: req = {~raw_a, raw_a};
      PM_SYNC: req = {raw_a, raw_a};
      default: req = {raw_b, raw_a};
    endcase
    if (!en) req = 2'b00;
  end

  for (genvar j = 0; j < 2; j++) begin : g_leg
    logic [DTW-1:0] hcnt;
    always_ff @(posedge clk) begin
      if (rst || !req[j]) begin
        hcnt <= '0;
      end else if (ce && (hcnt < dt_eff)) begin
        hcnt <= hcnt + 1'b1;
      end
    end
    assign q[j] = req[j] && (hcnt >= dt_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) pwm <= 2'b00;
    else     pwm <= q;
  end

endmodule

// File: rtl/pwm6_motor_pwm.sv
module pwm6_motor_pwm
  import pwm6_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NPAIR = 3,
  parameter int DTW   = 8,
  parameter int AW    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_tick,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  output logic [2*NPAIR-1:0] pwm_out,
  output logic               period_evt
);
  localparam int NCH = 2 * NPAIR;

  ctrl_t                  ctrl_q;
  pair_mode_e [NPAIR-1:0] mode_q;
  logic [DW-1:0]          per_act;
  logic [NCH-1:0][DW-1:0] duty_act;
  logic [NCH-1:0][DW-1:0] duty_eff;
  logic [DTW-1:0]         dead_q;
  logic                   ce;
  logic                   bound;
  logic [DW-1:0]          cnt_q;
  logic                   run_q;

  assign run_q = ctrl_q.run;

  pwm6_regs #(.DW(DW), .NPAIR(NPAIR), .DTW(DTW), .AW(AW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bound(bound), .ctrl_q(ctrl_q), .mode_q(mode_q), .per_act(per_act),
    .duty_act(duty_act), .dead_q(dead_q)
  );

  pwm6_tick tick_i (
    .clk(clk), .rst(rst), .run(run_q), .ext_sel(ctrl_q.ext_sel),
    .ext_tick(ext_tick), .pre_exp(ctrl_q.pre_exp), .ce(ce)
  );

  pwm6_counter #(.DW(DW)) cnt_i (
    .clk(clk), .rst(rst), .run(run_q), .center(ctrl_q.center), .ce(ce),
    .period(per_act), .cnt_q(cnt_q), .bound(bound)
  );

  // group mode: higher pairs borrow the duties of pair 0
  for (genvar c = 0; c < NCH; c++) begin : g_duty
    if (c < 2) begin : g_base
      assign duty_eff[c] = duty_act[c];
    end else begin : g_alias
      assign duty_eff[c] = ctrl_q.group ? duty_act[c % 2] : duty_act[c];
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm6_pair #(.DW(DW), .DTW(DTW)) pair_i (
      .clk(clk), .rst(rst), .en(run_q), .ce(ce), .mode(mode_q[p]),
      .cnt(cnt_q), .duty_a(duty_eff[2*p]), .duty_b(duty_eff[2*p+1]),
      .dead(dead_q), .pwm(pwm_out[2*p +: 2])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) period_evt <= 1'b0;
    else     period_evt <= bound;
  end

endmodule

// File: rtl/pwm6_checker.sv
module pwm6_checker
  import pwm6_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NPAIR = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [2*NPAIR-1:0]     pwm_out,
  input logic                   period_evt,
  input pair_mode_e [NPAIR-1:0] mode,
  input logic                   run,
  input logic [DW-1:0]          cnt,
  input logic [DW-1:0]          per_act,
  input logic                   bound
);

  p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!run) |-> (pwm_out == '0));

  p_evt_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    period_evt |-> (cnt == '0));

  p_period_load_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(per_act) |-> $past(bound || !run));

  for (genvar p = 0; p < NPAIR; p++) begin : g_chk
    p_comp_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
      ($past(mode[p]) == PM_COMP) |-> !(pwm_out[2*p] && pwm_out[2*p+1]));

    p_sync_follow_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(mode[p]) == PM_SYNC) |-> (pwm_out[2*p+1] == pwm_out[2*p]));
  end

endmodule

bind pwm6_motor_pwm pwm6_checker #(.DW(DW), .NPAIR(NPAIR)) chk_i (
  .clk(clk), .rst(rst), .pwm_out(pwm_out), .period_evt(period_evt),
  .mode(mode_q), .run(run_q), .cnt(cnt_q), .per_act(per_act), .bound(bound)
);

// File: tb/pwm6_motor_pwm_tb_top.sv
module pwm6_motor_pwm_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  pwm_out;
  logic        period_evt;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int hi[6];
  int evts, evt_adj;
  int overlap[3];
  int mism[3];
  int ext_ph = 0;

  always #10 clk = ~clk;

  pwm6_motor_pwm dut_i (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
    .period_evt(period_evt)
  );

  // external tick: one clock high out of every three
  initial begin
    forever begin
      @(negedge clk);
      ext_ph   = (ext_ph == 2) ? 0 : ext_ph + 1;
      ext_tick = (ext_ph == 0);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a[3:0];
    wr_data = d[15:0];
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  function automatic int ctrl_word(input int run, input int center, input int ext,
                                   input int pexp, input int group,
                                   input int m0, input int m1, input int m2);
    return run | (center << 1) | (ext << 2) | (pexp << 3) | (group << 6)
           | (m0 << 7) | (m1 << 9) | (m2 << 11);
  endfunction

  // stop, write the shadows, arm a load (moves at once while halted), then start
  task automatic setup(input int center, input int ext, input int pexp, input int group,
                       input int m0, input int m1, input int m2,
                       input int per, input int d[6], input int dt);
    wr(0, ctrl_word(0, center, ext, pexp, group, m0, m1, m2));
    wr(1, per);
    for (int i = 0; i < 6; i++) wr(2 + i, d[i]);
    wr(8, dt);
    wr(9, 0);
    repeat (2) @(negedge clk);
    wr(0, ctrl_word(1, center, ext, pexp, group, m0, m1, m2));
    repeat (200) @(negedge clk);
  endtask

  task automatic measure(input int n);
    bit prev = 1'b0;
    for (int c = 0; c < 6; c++) hi[c] = 0;
    for (int p = 0; p < 3; p++) begin overlap[p] = 0; mism[p] = 0; end
    evts = 0;
    evt_adj = 0;
    repeat (n) begin
      @(negedge clk);
      for (int c = 0; c < 6; c++) hi[c] += int'(pwm_out[c]);
      evts += int'(period_evt);
      if (period_evt && prev) evt_adj++;
      prev = period_evt;
      for (int p = 0; p < 3; p++) begin
        overlap[p] += int'(pwm_out[2*p] & pwm_out[2*p+1]);
        mism[p]    += int'(pwm_out[2*p] != pwm_out[2*p+1]);
      end
    end
  endtask

  task automatic t_reset();
    int zeros = 0;
    // R1: quiet in reset and while stopped even with duties loaded
    check("R1", "pwm_out in reset", int'(pwm_out), 0);
    check("R1", "period_evt in reset", int'(period_evt), 0);
    @(negedge clk);
    rst = 1'b0;
    wr(1, 9);
    for (int i = 0; i < 6; i++) wr(2 + i, 5);
    wr(9, 0);
    repeat (5) @(negedge clk);
    measure(30);
    for (int c = 0; c < 6; c++) zeros += hi[c];
    check("R1", "high clocks while stopped", zeros, 0);
    check("R1", "events while stopped", evts, 0);
  endtask

  task automatic t_edge();
    int exp_hi[6] = '{0, 15, 50, 45, 25, 5};
    setup(0, 0, 0, 0, 0, 0, 0, 9, '{0, 3, 10, 9, 5, 1}, 0);
    measure(50);
    for (int c = 0; c < 6; c++) check("R2/R10", $sformatf("edge ch%0d high", c), hi[c], exp_hi[c]);
    check("R6", "edge events in 5 periods", evts, 5);
    check("R6", "edge back-to-back events", evt_adj, 0);
  endtask

  task automatic t_center();
    int exp_hi[6] = '{0, 1, 7, 15, 16 * 3, 5};
    setup(1, 0, 0, 0, 0, 0, 0, 8, '{0, 1, 4, 8, 9, 3}, 0);
    measure(48);
    exp_hi[1] = 3; exp_hi[2] = 21; exp_hi[3] = 45; exp_hi[5] = 15;
    for (int c = 0; c < 6; c++) check("R3", $sformatf("center ch%0d high", c), hi[c], exp_hi[c]);
    check("R6", "center events in 3 periods", evts, 3);
  endtask

  task automatic t_prescale();
    setup(0, 0, 2, 0, 0, 0, 0, 4, '{2, 0, 0, 0, 0, 0}, 0);
    measure(60);
    check("R4", "divide-by-4 ch0 high", hi[0], 24);
    check("R4", "divide-by-4 events", evts, 3);
  endtask

  task automatic t_ext();
    setup(0, 1, 0, 0, 0, 0, 0, 4, '{2, 0, 0, 0, 0, 0}, 0);
    measure(45);
    check("R4", "external tick ch0 high", hi[0], 18);
    check("R4", "external tick events", evts, 3);
  endtask

  task automatic t_shadow();
    setup(0, 0, 0, 0, 0, 0, 0, 9, '{3, 0, 0, 0, 0, 0}, 0);
    wr(2, 7);
    repeat (30) @(negedge clk);
    measure(50);
    check("R5", "duty written without load", hi[0], 15);
    wr(9, 0);
    repeat (40) @(negedge clk);
    measure(50);
    check("R5", "duty after load", hi[0], 35);
  endtask

  task automatic t_group();
    setup(0, 0, 0, 1, 0, 0, 0, 9, '{3, 6, 1, 2, 8, 9}, 0);
    measure(50);
    check("R7", "group ch2 follows ch0", hi[2], 15);
    check("R7", "group ch3 follows ch1", hi[3], 30);
    check("R7", "group ch4 follows ch0", hi[4], 15);
    check("R7", "group ch5 follows ch1", hi[5], 30);
    wr(0, ctrl_word(1, 0, 0, 0, 0, 0, 0, 0));
    repeat (30) @(negedge clk);
    measure(50);
    check("R7", "group off ch2 own duty", hi[2], 5);
    check("R7", "group off ch5 own duty", hi[5], 45);
  endtask

  task automatic t_sync();
    setup(0, 0, 0, 0, 0, 2, 0, 9, '{0, 0, 6, 2, 0, 0}, 0);
    measure(50);
    check("R8", "sync ch2 high", hi[2], 30);
    check("R8", "sync ch3 high", hi[3], 30);
    check("R8", "sync pair mismatch clocks", mism[1], 0);
  endtask

  task automatic t_comp();
    setup(0, 0, 0, 0, 1, 0, 0, 9, '{4, 0, 0, 0, 0, 0}, 2);
    measure(50);
    check("R9", "comp even high after dead time", hi[0], 10);
    check("R9", "comp odd high after dead time", hi[1], 20);
    check("R9", "comp overlap clocks", overlap[0], 0);
    setup(0, 0, 0, 0, 1, 0, 0, 9, '{1, 0, 0, 0, 0, 0}, 2);
    measure(50);
    check("R9", "short pulse suppressed", hi[0], 0);
    check("R9", "odd long phase", hi[1], 35);
    check("R9", "comp overlap clocks short", overlap[0], 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_edge();
    t_center();
    t_prescale();
    t_ext();
    t_shadow();
    t_group();
    t_sync();
    t_comp();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule